// File: doc/BRIEF.md
# Soft Interrupt Pending Register

This block keeps one word of pending interrupt bits, fed by software and by two timer-match events, and turns that word into a vector of per-level interrupt requests. Software changes the word through three write strobes that share one data bus. One loads the word outright. One ORs the data into it. One clears the bits where the data is one. A read port returns the word with every bit above the top level reading as zero.

The request vector has one entry per level, 0 to 16. The middle levels (1 to 15) each compare their own index against the current processor interrupt level (PIL) and request only when the index is strictly higher. The two timer-match bits, level 0 (tick) and level 16 (system tick), skip that per-level test. They are gated only by a fixed threshold: they request while PIL is below 14. Two single-cycle hardware strobes from the timer-match logic set those two bits. Requests are combinational from the stored word and the live PIL, so a change in either shows up in the same cycle. Choosing among the requests, and taking the trap, belong to the consumer.

Top module: `softint_pend`

## Requirements
- R1: After a synchronous active-low reset the stored word is zero, so `rd_data` reads 0 and every request is low.
- R2: A load strobe (`wr_load`) replaces the word with the low 17 bits of `wr_data`. Bits 17 and up of `rd_data` always read zero.
- R3: A set strobe (`wr_set`) makes the word the OR of its old value and the low 17 bits of `wr_data`.
- R4: A clear strobe (`wr_clr`) makes the word the AND of its old value and the inverted low 17 bits of `wr_data`.
- R5: For each level i from 1 to 15, `irq_req[i]` is high exactly when bit i of the word is set and i is strictly greater than `pil`.
- R6: `irq_req[0]` and `irq_req[16]` are high exactly when their bit is set and `pil` is below 14. Their own index plays no part.
- R7: `hw_tick_set` sets bit 0 and `hw_stick_set` sets bit 16 at the next edge. This holds even when a software load or clear in the same cycle would have cleared that bit: the hardware set wins.
- R8: Requests follow a change of `pil` or of the word with no added register stage. A rise in `pil` or a cleared bit drops the request in the same cycle.
- R9: When more than one software strobe is high in one cycle, load takes priority over set, and set takes priority over clear. Only the winning strobe acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_load | input | 1 | Load the word from `wr_data` |
| wr_set | input | 1 | OR `wr_data` into the word |
| wr_clr | input | 1 | Clear the word where `wr_data` is one |
| wr_data | input | 32 | Software write data |
| hw_tick_set | input | 1 | Tick-match strobe, sets bit 0 |
| hw_stick_set | input | 1 | System-tick-match strobe, sets bit 16 |
| pil | input | 4 | Current processor interrupt level |
| rd_data | output | 32 | Stored word, zero-extended |
| irq_req | output | 17 | Request per level 0 to 16 |

## Verification
The assertions take for granted that `pil`, the strobes and `wr_data` are free of unknown values at each edge. They also assume that any mix of strobes may arrive together. For that reason the set and clear checks apply only when the higher-priority strobes are low, and they ignore the timer bits when a hardware strobe can override them. The stimulus draws every input from `$urandom` with a fixed seed, masked to its port width. This exercises overlapping strobes, hardware sets that collide with clears, and `pil` values on both sides of the fixed threshold, including 13, 14 and 15. Directed steps also change `pil` between edges to observe the same-cycle response.

// File: rtl/softint_pkg.sv
// Package: shared types for the soft interrupt pending register.
// Assumes nothing beyond the users importing it.
package softint_pkg;
    // Software operation selected for the current cycle.
    typedef enum logic [1:0] {
        SW_NONE = 2'd0,
        SW_LOAD = 2'd1,
        SW_SET  = 2'd2,
        SW_CLR  = 2'd3
    } sw_op_e;
endpackage

// File: rtl/softint_wr_decode.sv
// Module: softint_wr_decode
// Picks one software operation from the three write strobes.
// Assumes the strobes may overlap; load outranks set, set outranks clear.
module softint_wr_decode
    import softint_pkg::*;
(
    input  logic   wr_load,
    input  logic   wr_set,
    input  logic   wr_clr,
    output sw_op_e op
);
    // Fixed-priority selection of the winning strobe.
    always_comb begin
        if (wr_load)     op = SW_LOAD;
        else if (wr_set) op = SW_SET;
        else if (wr_clr) op = SW_CLR;
        else             op = SW_NONE;
    end
endmodule

// File: rtl/softint_store.sv
// Module: softint_store
// Holds the pending word and applies the software operation, then the
// hardware timer-match sets, which win over any software clear.
// Assumes LEVELS >= 2; bit 0 and bit LEVELS-1 are the timer bits.
module softint_store
    import softint_pkg::*;
#(
    parameter int LEVELS = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sw_op_e            op,
    input  logic [LEVELS-1:0] data,
    input  logic              hw_lo_set,
    input  logic              hw_hi_set,
    output logic [LEVELS-1:0] q
);
    localparam int TOP = LEVELS - 1;

    logic [LEVELS-1:0] nxt;

    // Next-state word: software op first, then hardware sets on top.
    always_comb begin
        unique case (op)
            SW_LOAD: nxt = data;
            SW_SET:  nxt = q | data;
            SW_CLR:  nxt = q & ~data;
            default: nxt = q;
        endcase
        if (hw_lo_set) nxt[0]   = 1'b1;
        if (hw_hi_set) nxt[TOP] = 1'b1;
    end

    // Storage register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/softint_req_filter.sv
// Module: softint_req_filter
// Turns the pending word into per-level requests against the live PIL.
// Middle levels need index > pil; the two timer levels need pil < GATE_LVL.
// Purely combinational; assumes pil is stable around the sampling edge.
module softint_req_filter #(
    parameter int LEVELS   = 17,
    parameter int PIL_W    = 4,
    parameter int GATE_LVL = 14
) (
    input  logic [LEVELS-1:0] q,
    input  logic [PIL_W-1:0]  pil,
    output logic [LEVELS-1:0] req
);
    localparam int TOP = LEVELS - 1;

    logic below_gate;

    // Shared threshold test for the timer levels.
    assign below_gate = (int'(pil) < GATE_LVL);

    for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
        if (i == 0 || i == TOP) begin : g_timer
            // Timer level: fixed threshold only.
            assign req[i] = q[i] & below_gate;
        end else begin : g_mid
            // Middle level: strictly above the current level.
            assign req[i] = q[i] & (i > int'(pil));
        end
    end
endmodule

// File: rtl/softint_pend.sv
// Module: softint_pend (top)
// Soft interrupt pending register with load/set/clear write strobes,
// timer-match hardware sets and PIL-filtered request outputs.
// Assumes DATA_W > LEVELS; upper read bits are zero.
module softint_pend
    import softint_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LEVELS   = 17,
    parameter int PIL_W    = 4,
    parameter int GATE_LVL = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hw_tick_set,
    input  logic              hw_stick_set,
    input  logic [PIL_W-1:0]  pil,
    output logic [DATA_W-1:0] rd_data,
    output logic [LEVELS-1:0] irq_req
);
    localparam int PAD_W = DATA_W - LEVELS;

    sw_op_e            op;
    logic [LEVELS-1:0] word_q;

    softint_wr_decode u_dec (
        .wr_load (wr_load),
        .wr_set  (wr_set),
        .wr_clr  (wr_clr),
        .op      (op)
    );

    softint_store #(.LEVELS(LEVELS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .data      (wr_data[LEVELS-1:0]),
        .hw_lo_set (hw_tick_set),
        .hw_hi_set (hw_stick_set),
        .q         (word_q)
    );

    softint_req_filter #(
        .LEVELS   (LEVELS),
        .PIL_W    (PIL_W),
        .GATE_LVL (GATE_LVL)
    ) u_filt (
        .q   (word_q),
        .pil (pil),
        .req (irq_req)
    );

    // Zero-extended read of the stored word.
    assign rd_data = {{PAD_W{1'b0}}, word_q};
endmodule

// File: rtl/softint_pend_chk.sv
// Module: softint_pend_chk
// Property checker bound to softint_pend; watches ports only.
// Assumes inputs are known at each clock edge.
module softint_pend_chk #(
    parameter int DATA_W   = 32,
    parameter int LEVELS   = 17,
    parameter int PIL_W    = 4,
    parameter int GATE_LVL = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_load,
    input logic              wr_set,
    input logic              wr_clr,
    input logic [DATA_W-1:0] wr_data,
    input logic              hw_tick_set,
    input logic              hw_stick_set,
    input logic [PIL_W-1:0]  pil,
    input logic [DATA_W-1:0] rd_data,
    input logic [LEVELS-1:0] irq_req
);
    localparam int TOP = LEVELS - 1;
    localparam logic [LEVELS-1:0] MID_MASK = {1'b0, {(LEVELS-2){1'b1}}, 1'b0};

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data >> LEVELS) == '0) else $error("upper bits set"); // R2

    AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_load) |=>
        ((rd_data[LEVELS-1:0] & $past(wr_data[LEVELS-1:0])) == $past(wr_data[LEVELS-1:0])))
        else $error("set alias lost bits"); // R3

    AST_CLR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_load && !wr_set) |=>
        ((rd_data[LEVELS-1:0] & $past(wr_data[LEVELS-1:0]) & MID_MASK) == '0))
        else $error("clear alias left bits"); // R4

    AST_REQ_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~rd_data[LEVELS-1:0]) == '0) else $error("request without bit"); // R5

    AST_TIMER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pil) >= GATE_LVL) |-> (!irq_req[0] && !irq_req[TOP]))
        else $error("timer request above gate"); // R6

    AST_HW_TICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_tick_set |=> rd_data[0]) else $error("tick set lost"); // R7

    AST_HW_STICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stick_set |=> rd_data[TOP]) else $error("stick set lost"); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && !hw_tick_set && !hw_stick_set) |=>
        (rd_data[LEVELS-1:0] == $past(wr_data[LEVELS-1:0])))
        else $error("load did not win"); // R9
endmodule

bind softint_pend softint_pend_chk #(
    .DATA_W   (DATA_W),
    .LEVELS   (LEVELS),
    .PIL_W    (PIL_W),
    .GATE_LVL (GATE_LVL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_load      (wr_load),
    .wr_set       (wr_set),
    .wr_clr       (wr_clr),
    .wr_data      (wr_data),
    .hw_tick_set  (hw_tick_set),
    .hw_stick_set (hw_stick_set),
    .pil          (pil),
    .rd_data      (rd_data),
    .irq_req      (irq_req)
);

// File: tb/softint_pend_tb.sv
`timescale 1ns/1ps
// Bench for softint_pend: directed corners plus seeded random stimulus,
// compared against a behavioural model kept in bench functions.
module softint_pend_tb;
    localparam int DATA_W = 32;
    localparam int LEVELS = 17;
    localparam int PIL_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_load = 1'b0, wr_set = 1'b0, wr_clr = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              hw_tick_set = 1'b0, hw_stick_set = 1'b0;
    logic [PIL_W-1:0]  pil = '0;
    logic [DATA_W-1:0] rd_data;
    logic [LEVELS-1:0] irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [LEVELS-1:0] model = '0;

    softint_pend u_dut (
        .clk(clk), .rst_n(rst_n), .wr_load(wr_load), .wr_set(wr_set),
        .wr_clr(wr_clr), .wr_data(wr_data), .hw_tick_set(hw_tick_set),
        .hw_stick_set(hw_stick_set), .pil(pil), .rd_data(rd_data),
        .irq_req(irq_req)
    );

    always #10 clk = ~clk;

    // Expected requests from a word and a level.
    function automatic logic [LEVELS-1:0] exp_req(logic [LEVELS-1:0] w, int lvl);
        logic [LEVELS-1:0] r;
        for (int i = 0; i < LEVELS; i++) begin
            if (i == 0 || i == LEVELS-1) r[i] = w[i] && (lvl < 14);
            else                         r[i] = w[i] && (i > lvl);
        end
        return r;
    endfunction

    // Expected next word from the write rules.
    function automatic logic [LEVELS-1:0] exp_next(logic [LEVELS-1:0] w, logic ld,
            logic st, logic cl, logic [LEVELS-1:0] d, logic ht, logic hs);
        logic [LEVELS-1:0] n;
        if (ld)      n = d;
        else if (st) n = w | d;
        else if (cl) n = w & ~d;
        else         n = w;
        if (ht) n[0] = 1'b1;
        if (hs) n[LEVELS-1] = 1'b1;
        return n;
    endfunction

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, check after the rise.
    task automatic cyc(string tag, logic ld, logic st, logic cl, logic [DATA_W-1:0] d,
                       logic ht, logic hs, logic [PIL_W-1:0] p);
        @(negedge clk);
        wr_load = ld; wr_set = st; wr_clr = cl; wr_data = d;
        hw_tick_set = ht; hw_stick_set = hs; pil = p;
        @(posedge clk);
        model = exp_next(model, ld, st, cl, d[LEVELS-1:0], ht, hs);
        #1;
        chk({tag, " word"}, rd_data, {{(DATA_W-LEVELS){1'b0}}, model});
        chk({tag, " req"}, {{(DATA_W-LEVELS){1'b0}}, irq_req},
            {{(DATA_W-LEVELS){1'b0}}, exp_req(model, int'(p))});
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset word", rd_data, '0);
        chk("R1 reset req", {15'd0, irq_req}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: load all ones, upper bits must read zero
        cyc("R2 load", 1, 0, 0, 32'hFFFF_FFFF, 0, 0, 4'd0);
        // R5 / R6 sweep of pil over a full word
        for (int p = 0; p < 16; p++) cyc("R5 R6 pil sweep", 0, 0, 0, 0, 0, 0, 4'(p));
        // R4: clear middle bits
        cyc("R4 clear", 0, 0, 1, 32'h0000_AAAA, 0, 0, 4'd3);
        // R3: set aliases ORs in
        cyc("R3 set", 0, 1, 0, 32'h0000_0155, 0, 0, 4'd3);
        // R7: hardware sets beat a full clear
        cyc("R7 clear all", 0, 0, 1, 32'h0001_FFFF, 0, 0, 4'd13);
        cyc("R7 hw vs clear", 0, 0, 1, 32'h0001_FFFF, 1, 1, 4'd13);
        chk("R7 timer bits", rd_data, 32'h0001_0001);
        cyc("R7 hw vs load", 1, 0, 0, 32'h0000_0000, 1, 0, 4'd13);
        // R9: simultaneous strobes
        cyc("R9 set over clr", 0, 1, 1, 32'h0000_0F00, 0, 0, 4'd0);
        cyc("R9 load over set", 1, 1, 1, 32'h0000_0030, 0, 0, 4'd0);
        // R8: pil change between edges, response with no clock
        cyc("R8 prep", 1, 0, 0, 32'h0001_8001, 0, 0, 4'd2);
        @(negedge clk);
        wr_load = 0; pil = 4'd14;
        #1;
        chk("R8 pil rise same cycle", {15'd0, irq_req}, {15'd0, exp_req(model, 14)});
        pil = 4'd13;
        #1;
        chk("R8 pil fall same cycle", {15'd0, irq_req}, {15'd0, exp_req(model, 13)});

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [3:0] ctl;
            ctl = 4'($urandom);
            cyc("R3 R4 R5 R6 R7 R9 random", ($urandom % 6) == 0, ctl[0], ctl[1],
                $urandom, ($urandom % 5) == 0, ($urandom % 5) == 0, 4'($urandom));
        end

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 rereset", rd_data, '0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule